// File: doc/BRIEF.md
# VLIW Bundle Issue Unit

The unit takes one fixed-format very long instruction word per clock and splits it into five operation slots. Two slots carry memory references, two carry floating-point operations and one carries an integer or branch operation. Every occupied slot whose opcode suits its slot class goes out on its own functional-unit port, all in the cycle after the bundle is accepted. The unit does not reorder, stall or resolve hazards. The compiler must pack the bundle so that the operations can run together, and the hardware issues the bundle exactly as it was packed.

A per-register scoreboard holds the cycles that remain before each result may be consumed. The latency depends on the class of the producing operation. When an operation reads a register too early, the unit raises a sticky violation flag and records the slot that did it, and the operation still issues. An opcode in a slot of the wrong class is dropped and raises a sticky class error. A taken branch in the integer slot loads the bundle program counter with its target. Two counters, one of accepted bundles and one of issued slots, let slot efficiency be computed as slots / (5 × bundles).

Top module: `vliw_issue_unit`

## Requirements
- R1: After reset, every output is zero.
- R2: Bundle layout (128 bits): slot s occupies bits [24s+23:24s] for s = 0..4, and bits [127:120] are ignored. Slots 0 and 1 are memory slots, slots 2 and 3 are floating-point slots, and slot 4 is the integer/branch slot. Within a slot, bit 23 is valid, [22:20] is the opcode, [19:15] is the destination, [14:10] is the source and [9:0] is the immediate. Opcodes: 1 load, 2 store, 3 fp add, 4 fp multiply, 5 integer ALU, 6 branch. Opcodes 0 and 7 are legal in no slot.
- R3: A slot that is valid and legal for its class is issued on `issue_valid_o[s]` in the cycle after the bundle is accepted. The slot bits of the bundle appear unchanged on `issue_slot_o`. An empty slot issues nothing.
- R4: A valid slot whose opcode is illegal for its class is not issued and not counted. It sets the sticky `class_err_o`.
- R5: A consumer of a load result that issues 1 cycle after the load sets `lat_viol_o`. At 2 or more cycles after the load it does not.
- R6: A consumer of an fp add or fp multiply result that issues 2 cycles after the producer sets `lat_viol_o`. At 3 or more cycles it does not.
- R7: A consumer of an integer ALU result may issue 1 cycle after it without a violation.
- R8: `lat_viol_o` is sticky. `lat_viol_slot_o` holds the lowest violating slot index of the first violating bundle. The violating operation still issues.
- R9: A taken branch (issued in slot 4 with `br_cond_i` high) sets `pc_o` to its 10-bit immediate. Any other accepted bundle advances `pc_o` by one. The other slots of the branch bundle still issue.
- R10: `bundle_cnt_o` increments on every accepted bundle, including one with no occupied slot. `slot_cnt_o` increments by the number of slots issued.
- R11: In a cycle with `bundle_valid_i` low nothing issues, and `pc_o` and the counters hold. Latency is counted in clock cycles, so idle cycles count toward it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bundle_valid_i | input | 1 | Bundle present this cycle |
| bundle_i | input | 128 | Instruction bundle |
| br_cond_i | input | 1 | Branch condition from the integer datapath |
| issue_valid_o | output | 5 | Per-slot issue strobe |
| issue_slot_o | output | 120 | Issued slot fields, slot 0 in the low bits |
| pc_o | output | 10 | Bundle program counter |
| bundle_cnt_o | output | 16 | Accepted bundles |
| slot_cnt_o | output | 16 | Issued operations |
| lat_viol_o | output | 1 | Sticky latency violation |
| lat_viol_slot_o | output | 3 | Slot of the first violation |
| class_err_o | output | 1 | Sticky slot class error |

## Verification
The bench places consumers exactly one cycle short of each producer latency and then exactly at it. An off-by-one scoreboard fails this in one direction or the other, and so does one that counts bundles rather than clock cycles. It sends a second violating bundle after the first to catch a slot index that is overwritten instead of held. It puts a branch opcode in a memory slot to catch a design that redirects on the opcode alone. It sends an all-empty bundle and a header full of ones to expose a bundle counter that counts operations and decoding that leaks into the header bits.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int SLOT_W   = 24;
  localparam int NSLOT    = 5;
  localparam int HDR_W    = 8;
  localparam int BUNDLE_W = HDR_W + NSLOT * SLOT_W;
  localparam int REG_W    = 5;
  localparam int IMM_W    = 10;
  localparam int IDX_W    = $clog2(NSLOT);

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_FADD  = 3'd3,
    OP_FMUL  = 3'd4,
    OP_ALU   = 3'd5,
    OP_BR    = 3'd6,
    OP_RSVD  = 3'd7
  } op_e;

  typedef enum logic [1:0] {K_MEM, K_FP, K_INT} kind_e;

  typedef struct packed {
    logic             vld;
    op_e              op;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
    logic [IMM_W-1:0] imm;
  } slot_t;

  function automatic kind_e slot_kind(int s);
    if (s < 2) return K_MEM;
    if (s < 4) return K_FP;
    return K_INT;
  endfunction
endpackage

// File: rtl/vliw_slot_dec.sv
module vliw_slot_dec
  import vliw_pkg::*;
#(
  parameter kind_e KIND    = K_MEM,
  parameter int    LAT_LD  = 2,
  parameter int    LAT_FP  = 3,
  parameter int    LAT_ALU = 1,
  parameter int    LW      = 2
) (
  input  logic          vld_i,
  input  op_e           op_i,
  output logic          ok_o,
  output logic          bad_o,
  output logic          wr_o,
  output logic          br_o,
  output logic [LW-1:0] lat_o
);
  logic legal;

  always_comb begin
    case (KIND)
      K_MEM:   legal = (op_i == OP_LOAD) || (op_i == OP_STORE);
      K_FP:    legal = (op_i == OP_FADD) || (op_i == OP_FMUL);
      default: legal = (op_i == OP_ALU)  || (op_i == OP_BR);
    endcase
  end

  assign ok_o  = vld_i & legal;
  assign bad_o = vld_i & ~legal;
  assign wr_o  = (op_i == OP_LOAD) || (op_i == OP_FADD) ||
                 (op_i == OP_FMUL) || (op_i == OP_ALU);
  assign br_o  = (op_i == OP_BR);

  // stored value is latency-1: entry reaches zero exactly when use is legal
  always_comb begin
    if (op_i == OP_LOAD)                          lat_o = LW'(LAT_LD - 1);
    else if (op_i == OP_FADD || op_i == OP_FMUL)  lat_o = LW'(LAT_FP - 1);
    else                                          lat_o = LW'(LAT_ALU - 1);
  end
endmodule

// File: rtl/vliw_scoreboard.sv
module vliw_scoreboard
  import vliw_pkg::*;
#(
  parameter int NS = NSLOT,
  parameter int RW = REG_W,
  parameter int LW = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NS-1:0]          wr_en_i,
  input  logic [NS-1:0][RW-1:0]  wr_dst_i,
  input  logic [NS-1:0][LW-1:0]  wr_lat_i,
  input  logic [NS-1:0]          rd_en_i,
  input  logic [NS-1:0][RW-1:0]  rd_src_i,
  output logic [NS-1:0]          hazard_o
);
  localparam int NR = 1 << RW;

  logic [NR-1:0][LW-1:0] rem_q, rem_d;

  always_comb begin
    for (int r = 0; r < NR; r++)
      rem_d[r] = (rem_q[r] != '0) ? rem_q[r] - 1'b1 : '0;
    // higher slot wins on a duplicate destination
    for (int s = 0; s < NS; s++)
      if (wr_en_i[s]) rem_d[wr_dst_i[s]] = wr_lat_i[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rem_q <= '0;
    else         rem_q <= rem_d;
  end

  always_comb begin
    for (int s = 0; s < NS; s++)
      hazard_o[s] = rd_en_i[s] && (rem_q[rd_src_i[s]] != '0);
  end
endmodule

// File: rtl/vliw_issue_unit.sv
module vliw_issue_unit
  import vliw_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int LAT_LD  = 2,
  parameter int LAT_FP  = 3,
  parameter int LAT_ALU = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bundle_valid_i,
  input  logic [BUNDLE_W-1:0]       bundle_i,
  input  logic                      br_cond_i,
  output logic [NSLOT-1:0]          issue_valid_o,
  output logic [NSLOT*SLOT_W-1:0]   issue_slot_o,
  output logic [IMM_W-1:0]          pc_o,
  output logic [CNT_W-1:0]          bundle_cnt_o,
  output logic [CNT_W-1:0]          slot_cnt_o,
  output logic                      lat_viol_o,
  output logic [IDX_W-1:0]          lat_viol_slot_o,
  output logic                      class_err_o
);
  localparam int LAT_MAX = (LAT_FP > LAT_LD) ? ((LAT_FP > LAT_ALU) ? LAT_FP : LAT_ALU)
                                             : ((LAT_LD > LAT_ALU) ? LAT_LD : LAT_ALU);
  localparam int LW      = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1;

  slot_t [NSLOT-1:0]            slots;
  logic  [NSLOT-1:0]            ok, bad, wr, isbr, iss, cerr, hz;
  logic  [NSLOT-1:0][LW-1:0]    lat;
  logic  [NSLOT-1:0][REG_W-1:0] dst_v, src_v;
  logic  [IDX_W-1:0]            hz_idx;
  logic                         br_taken;
  logic                         unused_hdr;

  assign slots      = bundle_i[NSLOT*SLOT_W-1:0];
  assign unused_hdr = ^bundle_i[BUNDLE_W-1:NSLOT*SLOT_W];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    vliw_slot_dec #(
      .KIND(slot_kind(s)), .LAT_LD(LAT_LD), .LAT_FP(LAT_FP),
      .LAT_ALU(LAT_ALU), .LW(LW)
    ) u_dec (
      .vld_i(slots[s].vld), .op_i(slots[s].op),
      .ok_o(ok[s]), .bad_o(bad[s]), .wr_o(wr[s]), .br_o(isbr[s]), .lat_o(lat[s])
    );
    assign dst_v[s] = slots[s].dst;
    assign src_v[s] = slots[s].src;
  end

  assign iss  = ok  & {NSLOT{bundle_valid_i}};
  assign cerr = bad & {NSLOT{bundle_valid_i}};

  vliw_scoreboard #(.NS(NSLOT), .RW(REG_W), .LW(LW)) u_sb (
    .clk_i, .rst_ni,
    .wr_en_i (iss & wr),
    .wr_dst_i(dst_v),
    .wr_lat_i(lat),
    .rd_en_i (iss),
    .rd_src_i(src_v),
    .hazard_o(hz)
  );

  always_comb begin
    hz_idx = '0;
    for (int s = NSLOT - 1; s >= 0; s--)
      if (hz[s]) hz_idx = IDX_W'(s);
  end

  assign br_taken = iss[NSLOT-1] & isbr[NSLOT-1] & br_cond_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_valid_o   <= '0;
      issue_slot_o    <= '0;
      pc_o            <= '0;
      bundle_cnt_o    <= '0;
      slot_cnt_o      <= '0;
      lat_viol_o      <= 1'b0;
      lat_viol_slot_o <= '0;
      class_err_o     <= 1'b0;
    end else begin
      issue_valid_o <= iss;
      if (bundle_valid_i) begin
        issue_slot_o <= bundle_i[NSLOT*SLOT_W-1:0];
        pc_o         <= br_taken ? slots[NSLOT-1].imm : pc_o + 1'b1;
        bundle_cnt_o <= bundle_cnt_o + 1'b1;
        slot_cnt_o   <= slot_cnt_o + CNT_W'($countones(iss));
      end
      if (|hz && !lat_viol_o) begin
        lat_viol_o      <= 1'b1;
        lat_viol_slot_o <= hz_idx;
      end
      if (|cerr) class_err_o <= 1'b1;
    end
  end

  // R11: no bundle, no issue
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bundle_valid_i) |-> (issue_valid_o == '0 && $stable(pc_o)));
  // R10: slot counter tracks issue strobes
  p_slot_count_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_cnt_o == CNT_W'($past(slot_cnt_o) + CNT_W'($countones(issue_valid_o))));
  // R8
  p_viol_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_viol_o |=> (lat_viol_o && $stable(lat_viol_slot_o)));
  // R4
  p_class_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    class_err_o |=> class_err_o);
  // R9: sequential bundles advance the counter by one
  p_pc_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bundle_valid_i) && !$past(br_taken)) |-> pc_o == IMM_W'($past(pc_o) + 1'b1));
  // R4: a wrong-class slot never strobes its port
  p_suppress_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bundle_valid_i) |-> ((issue_valid_o & $past(bad)) == '0));
endmodule

// File: tb/vliw_issue_unit_bench.sv
`timescale 1ns/1ps
module vliw_issue_unit_bench;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bundle_valid_i = 1'b0;
  logic [127:0] bundle_i = '0;
  logic         br_cond_i = 1'b0;
  logic [4:0]   issue_valid_o;
  logic [119:0] issue_slot_o;
  logic [9:0]   pc_o;
  logic [15:0]  bundle_cnt_o, slot_cnt_o;
  logic         lat_viol_o, class_err_o;
  logic [2:0]   lat_viol_slot_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vliw_issue_unit u_vliw_issue_unit (
    .clk_i(clk), .rst_ni, .bundle_valid_i, .bundle_i, .br_cond_i,
    .issue_valid_o, .issue_slot_o, .pc_o, .bundle_cnt_o, .slot_cnt_o,
    .lat_viol_o, .lat_viol_slot_o, .class_err_o
  );

  localparam logic [2:0] LD = 3'd1, ST = 3'd2, FA = 3'd3, FM = 3'd4, AL = 3'd5, BR = 3'd6;

  function automatic logic [23:0] sl(logic [2:0] op, logic [4:0] dst, logic [4:0] src, logic [9:0] imm);
    return {1'b1, op, dst, src, imm};
  endfunction

  function automatic logic [127:0] bnd(logic [23:0] s0, logic [23:0] s1, logic [23:0] s2,
                                       logic [23:0] s3, logic [23:0] s4);
    return {8'hFF, s4, s3, s2, s1, s0};
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic [127:0] b, logic cond);
    bundle_i = b; bundle_valid_i = 1'b1; br_cond_i = cond;
    @(negedge clk);
    bundle_valid_i = 1'b0; br_cond_i = 1'b0; bundle_i = '0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 issue", issue_valid_o, 0);
    chk("R1 pc", pc_o, 0);
    chk("R1 counts", {bundle_cnt_o, slot_cnt_o}, 0);
    chk("R1 flags", {lat_viol_o, lat_viol_slot_o, class_err_o}, 0);
  endtask

  task automatic t_basic();
    logic [127:0] b1, b2;
    b1 = bnd(sl(LD,10,1,0), sl(ST,0,2,0), sl(FA,11,3,0), sl(FM,12,4,0), sl(AL,13,5,10'h21));
    step(b1, 1'b0);
    chk("R3 all slots", issue_valid_o, 5'h1f);
    chk("R2 R3 payload", issue_slot_o, b1[119:0]);
    chk("R10 counts 1", {bundle_cnt_o, slot_cnt_o}, {16'd1, 16'd5});
    b2 = bnd(24'h0, sl(ST,0,20,0), 24'h0, sl(FA,14,21,0), 24'h0);
    step(b2, 1'b0);
    chk("R3 sparse", issue_valid_o, 5'b01010);
    chk("R10 counts 2", {bundle_cnt_o, slot_cnt_o}, {16'd2, 16'd7});
    chk("R9 pc seq", pc_o, 10'd2);
  endtask

  task automatic t_idle();
    idle();
    chk("R11 idle issue", issue_valid_o, 0);
    chk("R11 idle hold", {pc_o, bundle_cnt_o, slot_cnt_o}, {10'd2, 16'd2, 16'd7});
    step(bnd(0,0,0,0,0), 1'b0);
    chk("R10 empty bundle", {pc_o, bundle_cnt_o, slot_cnt_o, issue_valid_o}, {10'd3, 16'd3, 16'd7, 5'd0});
  endtask

  task automatic t_class();
    chk("R4 clear", class_err_o, 0);
    step(bnd(sl(LD,15,22,0), 0, sl(ST,0,23,0), 0, {1'b1, 3'd0, 20'h0}), 1'b0);
    chk("R4 suppress", issue_valid_o, 5'b00001);
    chk("R4 flag", class_err_o, 1);
    chk("R4 count", slot_cnt_o, 16'd8);
    chk("R4 no viol", lat_viol_o, 0);
  endtask

  task automatic t_lat_load();
    do_reset();
    step(bnd(sl(LD,5,0,0),0,0,0,0), 1'b0);
    chk("R5 producer", lat_viol_o, 0);
    step(bnd(0,0,sl(FA,6,5,0),0,0), 1'b0);
    chk("R5 early", {lat_viol_o, lat_viol_slot_o}, {1'b1, 3'd2});
    chk("R8 still issues", issue_valid_o, 5'b00100);
    do_reset();
    step(bnd(sl(LD,5,0,0),0,0,0,0), 1'b0);
    idle();
    step(bnd(0,0,sl(FA,6,5,0),0,0), 1'b0);
    chk("R5 R11 on time", lat_viol_o, 0);
  endtask

  task automatic t_lat_fp();
    do_reset();
    step(bnd(0,0,sl(FA,7,0,0),0,0), 1'b0);
    idle();
    step(bnd(0,sl(ST,0,7,0),0,0,0), 1'b0);
    chk("R6 early", {lat_viol_o, lat_viol_slot_o}, {1'b1, 3'd1});
    do_reset();
    step(bnd(0,0,0,sl(FM,7,0,0),0), 1'b0);
    idle(); idle();
    step(bnd(0,sl(ST,0,7,0),0,0,0), 1'b0);
    chk("R6 on time", lat_viol_o, 0);
  endtask

  task automatic t_lat_int();
    do_reset();
    step(bnd(0,0,0,0,sl(AL,3,0,0)), 1'b0);
    step(bnd(0,0,0,0,sl(BR,0,3,10'h40)), 1'b0);
    chk("R7 next cycle", lat_viol_o, 0);
  endtask

  task automatic t_viol_first();
    do_reset();
    step(bnd(sl(LD,5,0,0),0,0,0,0), 1'b0);
    step(bnd(sl(LD,8,0,0), sl(ST,0,5,0), 0, sl(FA,9,5,0), 0), 1'b0);
    chk("R8 lowest slot", {lat_viol_o, lat_viol_slot_o}, {1'b1, 3'd1});
    chk("R8 issue", issue_valid_o, 5'b01011);
    step(bnd(0,0,0,0,sl(AL,1,8,0)), 1'b0);
    chk("R8 held", {lat_viol_o, lat_viol_slot_o}, {1'b1, 3'd1});
    chk("R8 issue 2", issue_valid_o, 5'b10000);
  endtask

  task automatic t_branch();
    do_reset();
    step(bnd(0,0,sl(FA,2,0,0),0,sl(BR,0,0,10'h155)), 1'b1);
    chk("R9 taken", pc_o, 10'h155);
    chk("R9 others issue", issue_valid_o, 5'b10100);
    step(bnd(0,0,0,0,sl(BR,0,0,10'h0AA)), 1'b0);
    chk("R9 not taken", pc_o, 10'h156);
    step(bnd(sl(BR,0,0,10'h003),0,0,0,0), 1'b1);
    chk("R9 R4 branch in mem slot", {pc_o, class_err_o, issue_valid_o}, {10'h157, 1'b1, 5'b0});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_idle();
    t_class();
    t_lat_load();
    t_lat_fp();
    t_lat_int();
    t_viol_first();
    t_branch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule